// File: doc/BRIEF.md
# Composite Memory Select Generator

This block drives one shared, active-low chip-select line from any chosen subset of four memory-space selects: program, data, boot and I/O. A 4-bit selection register holds one enable per source. The composite select goes low whenever an enabled source select is low. Typical use is one memory that serves two spaces. The composite line drives its chip select, and one of the individual selects serves as an extra address bit.

The same block passes the four individual selects on to the pins. A single bit in a system control word can switch off the boot select. A switched-off boot select stays high at its pin and also stops feeding the composite line. When the external bus is granted to another master, every select output, the composite included, is driven inactive. The individual outputs and the composite output pass through the same single output register, so their timing matches. Register writes take effect for the select requests of the following cycle.

Top module: `cms_gen`

## Requirements
- R1: During reset and right after it, every select output is high. The selection register resets to program=1, data=1, boot=0, I/O=1, and the boot-disable bit resets to 0. Bit positions in `sel_wdata_i`, `sel_req_ni` and `sel_no` are 0=program, 1=data, 2=boot, 3=I/O.
- R2: With the bus not granted, each individual output `sel_no[i]` equals `sel_req_ni[i]` as sampled at the previous clock edge. For the boot source this holds while its disable bit is 0.
- R3: With the bus not granted, `comp_sel_no` is low one cycle after any source whose enable bit is 1 has its request low.
- R4: A source whose enable bit is 0 has no effect on `comp_sel_no`. The composite is high one cycle after no enabled source is requesting.
- R5: Writing 1 to bit 3 of `ctl_wdata_i` with `ctl_we_i` high holds `sel_no[2]` high and removes the boot request from the composite. Writing 0 restores both.
- R6: While `bus_grant_i` is high, all of `sel_no` and `comp_sel_no` are high one cycle later, whatever the requests and enables are.
- R7: The composite and the individual outputs share the same single-cycle latency. A request change shows up on both in the same clock edge, and neither output responds before that edge.
- R8: Data on `sel_wdata_i` or `ctl_wdata_i` has no effect while its write enable is low. A written selection value applies to requests sampled at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_req_ni | input | 4 | Raw select requests, active low (0=program, 1=data, 2=boot, 3=I/O) |
| bus_grant_i | input | 1 | High while the external bus is granted to another master |
| sel_we_i | input | 1 | Write strobe for the selection register |
| sel_wdata_i | input | 4 | Selection register write data, one enable per source |
| ctl_we_i | input | 1 | Write strobe for the system control word |
| ctl_wdata_i | input | 16 | System control write data; bit 3 = 1 disables the boot select |
| sel_no | output | 4 | Gated individual selects, active low |
| comp_sel_no | output | 1 | Composite select, active low |

## Verification
The bench sweeps all 16 selection values, both boot-disable settings, both grant states and all 16 request patterns. From these it computes every expected output as a masked OR. The sweep tells enabled sources apart from masked ones. It also shows whether the boot disable reaches both the pin and the composite, and whether the grant overrides everything. Directed cases check the reset enables and pin the common latency, sampling just before and just after the capturing edge. Other cases show that data offered without a write strobe leaves behaviour unchanged.

// File: rtl/cms_pkg.sv
package cms_pkg;
  localparam int NUM_SRC      = 4;
  localparam int CTL_W        = 16;
  localparam int BOOT_DIS_BIT = 3;

  typedef enum logic [1:0] {
    SRC_PROG = 2'd0,
    SRC_DATA = 2'd1,
    SRC_BOOT = 2'd2,
    SRC_IO   = 2'd3
  } src_e;

  localparam int BOOT_IDX = int'(SRC_BOOT);

  // all enables set except the boot source
  function automatic logic [NUM_SRC-1:0] en_reset_val(input int boot_idx);
    logic [NUM_SRC-1:0] v;
    v = '1;
    v[boot_idx] = 1'b0;
    return v;
  endfunction
endpackage

// File: rtl/cms_cfg_regs.sv
module cms_cfg_regs #(
  parameter int NUM_SRC      = 4,
  parameter int BOOT_IDX     = 2,
  parameter int CTL_W        = 16,
  parameter int BOOT_DIS_BIT = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_we_i,
  input  logic [NUM_SRC-1:0] sel_wdata_i,
  input  logic               ctl_we_i,
  input  logic [CTL_W-1:0]   ctl_wdata_i,
  output logic [NUM_SRC-1:0] src_en_o,
  output logic               boot_dis_o
);
  localparam logic [NUM_SRC-1:0] EnRst = cms_pkg::en_reset_val(BOOT_IDX);

  logic [NUM_SRC-1:0] en_q;
  logic               dis_q;
  logic               ctl_unused;

  // only the boot-disable bit of the control word is held here
  assign ctl_unused = ^ctl_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= EnRst;
    end else if (sel_we_i) begin
      en_q <= sel_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q <= 1'b0;
    end else if (ctl_we_i) begin
      dis_q <= ctl_wdata_i[BOOT_DIS_BIT];
    end
  end

  assign src_en_o   = en_q;
  assign boot_dis_o = dis_q;
endmodule

// File: rtl/cms_src_gate.sv
module cms_src_gate #(
  parameter int NUM_SRC  = 4,
  parameter int BOOT_IDX = 2
) (
  input  logic [NUM_SRC-1:0] req_ni,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic               boot_dis_i,
  output logic [NUM_SRC-1:0] live_o,
  output logic               comp_o
);
  logic [NUM_SRC-1:0] live;
  logic [NUM_SRC-1:0] contrib;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i == BOOT_IDX) begin : g_boot
      assign live[i] = ~req_ni[i] & ~boot_dis_i;
    end else begin : g_plain
      assign live[i] = ~req_ni[i];
    end
    assign contrib[i] = live[i] & src_en_i[i];
  end

  assign live_o = live;
  assign comp_o = |contrib;
endmodule

// File: rtl/cms_out_stage.sv
module cms_out_stage #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               grant_i,
  input  logic [NUM_SRC-1:0] live_i,
  input  logic               comp_i,
  output logic [NUM_SRC-1:0] sel_no,
  output logic               comp_no
);
  logic [NUM_SRC-1:0] sel_q;
  logic               comp_q;

  // one register stage for every select keeps them edge-aligned
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '1;
      comp_q <= 1'b1;
    end else if (grant_i) begin
      sel_q  <= '1;
      comp_q <= 1'b1;
    end else begin
      sel_q  <= ~live_i;
      comp_q <= ~comp_i;
    end
  end

  assign sel_no  = sel_q;
  assign comp_no = comp_q;
endmodule

// File: rtl/cms_gen.sv
module cms_gen #(
  parameter int NUM_SRC      = cms_pkg::NUM_SRC,
  parameter int BOOT_IDX     = cms_pkg::BOOT_IDX,
  parameter int CTL_W        = cms_pkg::CTL_W,
  parameter int BOOT_DIS_BIT = cms_pkg::BOOT_DIS_BIT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] sel_req_ni,
  input  logic               bus_grant_i,
  input  logic               sel_we_i,
  input  logic [NUM_SRC-1:0] sel_wdata_i,
  input  logic               ctl_we_i,
  input  logic [CTL_W-1:0]   ctl_wdata_i,
  output logic [NUM_SRC-1:0] sel_no,
  output logic               comp_sel_no
);
  logic [NUM_SRC-1:0] src_en;
  logic               boot_dis;
  logic [NUM_SRC-1:0] live;
  logic               comp_live;

  cms_cfg_regs #(
    .NUM_SRC(NUM_SRC), .BOOT_IDX(BOOT_IDX),
    .CTL_W(CTL_W), .BOOT_DIS_BIT(BOOT_DIS_BIT)
  ) u_cfg (
    .clk_i, .rst_ni,
    .sel_we_i, .sel_wdata_i,
    .ctl_we_i, .ctl_wdata_i,
    .src_en_o(src_en), .boot_dis_o(boot_dis)
  );

  cms_src_gate #(.NUM_SRC(NUM_SRC), .BOOT_IDX(BOOT_IDX)) u_gate (
    .req_ni(sel_req_ni), .src_en_i(src_en), .boot_dis_i(boot_dis),
    .live_o(live), .comp_o(comp_live)
  );

  cms_out_stage #(.NUM_SRC(NUM_SRC)) u_out (
    .clk_i, .rst_ni, .grant_i(bus_grant_i),
    .live_i(live), .comp_i(comp_live),
    .sel_no(sel_no), .comp_no(comp_sel_no)
  );
endmodule

// File: rtl/cms_gen_chk.sv
module cms_gen_chk #(
  parameter int NUM_SRC  = 4,
  parameter int BOOT_IDX = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] sel_req_ni,
  input logic               bus_grant_i,
  input logic [NUM_SRC-1:0] sel_no,
  input logic               comp_sel_no,
  input logic [NUM_SRC-1:0] src_en,
  input logic               boot_dis
);
  logic [NUM_SRC-1:0] act_mask;
  always_comb begin
    act_mask = src_en;
    if (boot_dis) act_mask[BOOT_IDX] = 1'b0;
  end

  assert_grant_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_grant_i |=> (sel_no == '1) && comp_sel_no);

  assert_comp_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_grant_i && (|(~sel_req_ni & act_mask))) |=> !comp_sel_no);

  assert_comp_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_grant_i && !(|(~sel_req_ni & act_mask))) |=> comp_sel_no);

  assert_boot_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_dis |=> sel_no[BOOT_IDX]);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_follow
    if (i != BOOT_IDX) begin : g_chk
      assert_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_grant_i |=> sel_no[i] == $past(sel_req_ni[i]));
    end
  end
endmodule

bind cms_gen cms_gen_chk #(.NUM_SRC(NUM_SRC), .BOOT_IDX(BOOT_IDX)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_req_ni(sel_req_ni),
  .bus_grant_i(bus_grant_i), .sel_no(sel_no), .comp_sel_no(comp_sel_no),
  .src_en(src_en), .boot_dis(boot_dis)
);

// File: tb/sim_cms_gen.sv
module sim_cms_gen;
  localparam int CLK_PERIOD = 10;
  localparam int N = cms_pkg::NUM_SRC;
  localparam int BI = cms_pkg::BOOT_IDX;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req_n = '1;
  logic         grant = 1'b0;
  logic         sel_we = 1'b0;
  logic [N-1:0] sel_wd = '0;
  logic         ctl_we = 1'b0;
  logic [15:0]  ctl_wd = '0;
  logic [N-1:0] sel_n;
  logic         comp_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cms_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_req_ni(req_n), .bus_grant_i(grant),
    .sel_we_i(sel_we), .sel_wdata_i(sel_wd), .ctl_we_i(ctl_we),
    .ctl_wdata_i(ctl_wd), .sel_no(sel_n), .comp_sel_no(comp_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr_sel(input logic [N-1:0] v);
    @(negedge clk);
    sel_we = 1'b1; sel_wd = v;
    @(negedge clk);
    sel_we = 1'b0;
  endtask

  task automatic wr_ctl(input logic [15:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wd = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  // drive requests at a falling edge, sample at the next falling edge
  task automatic step(input logic [N-1:0] r, input logic g);
    req_n = r; grant = g;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset selects", {3'b0, comp_n, sel_n}, 8'h1F);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {3'b0, comp_n, sel_n}, 8'h1F);

    // reset enables: boot masked, others active
    step(4'b1011, 1'b0);
    chk("R1 boot reset enable 0", {7'b0, comp_n}, 8'h01);
    chk("R1 boot pin live", {4'b0, sel_n}, 8'h0B);
    step(4'b1110, 1'b0);
    chk("R1 program enable 1", {7'b0, comp_n}, 8'h00);
    step(4'b1101, 1'b0);
    chk("R1 data enable 1", {7'b0, comp_n}, 8'h00);
    step(4'b0111, 1'b0);
    chk("R1 io enable 1", {7'b0, comp_n}, 8'h00);
    step(4'b1111, 1'b0);

    // R7: no combinational path, both outputs move on the same edge
    req_n = 4'b1110;
    #1;
    chk("R7 before edge", {3'b0, comp_n, sel_n}, 8'h1F);
    @(negedge clk);
    chk("R7 after edge", {3'b0, comp_n, sel_n}, 8'h0E);
    step(4'b1111, 1'b0);

    // R8: data without strobe ignored
    wr_sel(4'b0001);
    sel_wd = 4'b1111; ctl_wd = 16'hFFFF;
    step(4'b1101, 1'b0);
    chk("R8 sel data no strobe", {7'b0, comp_n}, 8'h01);
    step(4'b1010, 1'b0);
    chk("R8 ctl data no strobe", {3'b0, comp_n, sel_n}, 8'h0A);

    // exhaustive sweep
    for (int en = 0; en < 16; en++) begin
      for (int dis = 0; dis < 2; dis++) begin
        wr_sel(en[N-1:0]);
        wr_ctl((16'(dis) << 3) | (16'(en) << 8) | 16'h0005);
        sel_wd = ~en[N-1:0];
        ctl_wd = (16'(1 - dis) << 3);
        for (int g = 0; g < 2; g++) begin
          for (int r = 0; r < 16; r++) begin
            logic [N-1:0] rv, exp_sel, act_src;
            logic exp_comp;
            string tc, ts;
            rv = r[N-1:0];
            step(rv, g[0]);
            act_src = ~rv & en[N-1:0];
            if (dis == 1) act_src[BI] = 1'b0;
            exp_sel = rv;
            if (dis == 1) exp_sel[BI] = 1'b1;
            exp_comp = ~(|act_src);
            if (g == 1) begin
              exp_sel = '1; exp_comp = 1'b1;
              tc = "R6 composite"; ts = "R6 individual";
            end else begin
              if (dis == 1 && !rv[BI]) tc = "R5 composite";
              else if (en != 15) tc = "R4 composite";
              else tc = "R3 composite";
              ts = (dis == 1) ? "R5 individual" : "R2 individual";
            end
            chk(tc, {7'b0, comp_n}, {7'b0, exp_comp});
            chk(ts, {4'b0, sel_n}, {4'b0, exp_sel});
          end
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule